// File: doc/BRIEF.md
# Per-Region Cache Usage Predictor

This block forecasts how busy each region of a cache will be in the next sampling period. A cache is divided into groups of sets, called regions here. At the end of every sampling period, monitoring logic sends one usage sample per region. Each sample is tagged with its region number. The block keeps the five most recent samples of every region. From that history alone it produces an explicit forecast of the region's next sample. The forecast is the floor of the mean of the newest samples, optionally adjusted by a weighted slope estimate. The adjusted value is then limited to the representable range.

Each forecast is also reduced to a coarse level, either 2 or 4 levels, using programmable thresholds. A scheduler can read the level directly. When a region's next real sample arrives, the level of that sample is compared with the level that was forecast for it. Two running counters record how many comparisons were made and how many of them disagreed. A synchronous clear input zeroes both counters.

Top module: `usage_pred_top`

## Requirements
- R1: For each accepted sample, the forecast equals floor(sum / n), taken over the n newest samples of that region, the new sample included. Here n = min(k, samples held, at most 5). The window length k is `winLen`, except that 0 is used as 1 and any value above 5 is used as 5.
- R2: A sample changes only the history of the region named by `sampleIdx`. The forecasts of other regions do not change.
- R3: `predValid` is high in exactly the cycle after each accepted sample. In that cycle it carries that sample's region on `predIdx`, and it is low otherwise.
- R4: When a region holds at least four samples, a trend correction is added to the mean. The correction is trunc(w·(3·h0 − h1 − h2 − h3) / (3·2^WGT_FRAC)), where h0 is the newest sample, w is `trendWeight`, and the division truncates toward zero. With a weight of zero, or fewer than four samples held, no correction is made.
- R5: The corrected forecast is clamped to the range 0 … 2^DATA_W − 1.
- R6: With `fourLevel` = 0, the level is 1 when the value is strictly greater than `thrLo`, and 0 otherwise.
- R7: With `fourLevel` = 1, the level (0…3) is the number of thresholds the value strictly exceeds. The thresholds are `thrLo` < `thrMid` < `thrHi`.
- R8: When a sample arrives for a region that already has a stored forecast, `cmpCount` increments. `missCount` also increments if the sample's level, under the current mode and thresholds, differs from the stored forecast level. The first sample of a region after reset makes no comparison.
- R9: `cntClear` zeroes both counters on the next cycle, even when a comparison happens in the same cycle. It leaves the histories unchanged.
- R10: After reset, `predValid` is low, both counters are zero, and every region holds no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A usage sample is present |
| sampleIdx | input | IDX_W | Region of the sample |
| sampleVal | input | DATA_W | Usage count of the sample |
| winLen | input | 3 | Averaging window length k |
| trendWeight | input | WGT_W | Trend weight, WGT_FRAC fraction bits |
| fourLevel | input | 1 | 1 selects 4-level quantizing, 0 selects 2-level |
| thrLo | input | DATA_W | Lowest threshold |
| thrMid | input | DATA_W | Middle threshold |
| thrHi | input | DATA_W | Highest threshold |
| cntClear | input | 1 | Synchronous clear of both counters |
| predValid | output | 1 | Forecast present |
| predIdx | output | IDX_W | Region of the forecast |
| predVal | output | DATA_W | Forecast usage |
| predLevel | output | 2 | Quantized forecast level |
| missCount | output | CNT_W | Level mismatches counted |
| cmpCount | output | CNT_W | Level comparisons made |

## Verification
The bench builds the block with four regions and 8-bit counters. The data width stays at 8 bits and the 3-bit weight keeps 3 fraction bits. With only four regions, samples to different regions can be interleaved, and every region fills its five-deep history within a handful of samples. Together these settings exercise the warm-up averaging, every window length, and trend estimates with enough history behind them. With 8-bit data and the largest weight, strongly rising and falling series push the corrected forecast past both clamp limits. Thresholds are probed at, and one above, each boundary in both level modes.

// File: rtl/usage_pred_pkg.sv
package usage_pred_pkg;

  // Strobes from control to datapath, one per accepted sample
  typedef struct packed {
    logic push;     // shift the sample into its region history
    logic compare;  // region holds a forecast to score
    logic miss;     // scored level disagreed
    logic clear;    // zero the counters
  } dpStrobes_t;

endpackage

// File: rtl/usage_pred_ctrl.sv
module usage_pred_ctrl
  import usage_pred_pkg::*;
#(
  parameter int NSS   = 32,
  parameter int IDX_W = $clog2(NSS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [IDX_W-1:0] sampleIdx,
  input  logic             cntClear,
  input  logic             levelDiffers,
  output dpStrobes_t       strb
);

  logic [NSS-1:0] havePred;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePred <= '0;
    end else if (sampleValid) begin
      havePred[sampleIdx] <= 1'b1;
    end
  end

  always_comb begin
    strb.push    = sampleValid;
    strb.compare = sampleValid && havePred[sampleIdx];
    strb.miss    = strb.compare && levelDiffers;
    strb.clear   = cntClear;
  end

endmodule

// File: rtl/usage_pred_dp.sv
module usage_pred_dp
  import usage_pred_pkg::*;
#(
  parameter int NSS      = 32,
  parameter int DATA_W   = 8,
  parameter int WGT_W    = 3,
  parameter int WGT_FRAC = 3,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = $clog2(NSS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [IDX_W-1:0]  sampleIdx,
  input  logic [DATA_W-1:0] sampleVal,
  input  logic [2:0]        winLen,
  input  logic [WGT_W-1:0]  trendWeight,
  input  logic              fourLevel,
  input  logic [DATA_W-1:0] thrLo,
  input  logic [DATA_W-1:0] thrMid,
  input  logic [DATA_W-1:0] thrHi,
  output logic              levelDiffers,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outVal,
  output logic [1:0]        outLevel,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  cmpCount
);

  localparam int HIST  = 5;
  localparam int RS    = 16;
  localparam int SUM_W = DATA_W + 3;
  localparam int D_W   = DATA_W + 3;
  localparam int P_W   = D_W + WGT_W + 1;
  localparam int T_W   = P_W + 2;
  localparam logic [RS:0] RCP1 = (RS+1)'(1 << RS);
  localparam logic [RS:0] RCP2 = (RS+1)'(1 << (RS - 1));
  localparam logic [RS:0] RCP3 = (RS+1)'(((1 << RS) + 2) / 3);
  localparam logic [RS:0] RCP4 = (RS+1)'(1 << (RS - 2));
  localparam logic [RS:0] RCP5 = (RS+1)'(((1 << RS) + 4) / 5);
  localparam logic signed [T_W-1:0] TOP_V = T_W'((1 << DATA_W) - 1);

  logic [DATA_W-1:0] hist [NSS][HIST];
  logic [2:0]        seenCnt [NSS];
  logic [1:0]        storedLvl [NSS];

  logic [DATA_W-1:0] win [HIST];
  logic [2:0]        seenNew, effK, nUse;
  logic [SUM_W-1:0]  winSum;
  logic [RS:0]       recipSel;
  logic [SUM_W+RS:0] meanProd;
  logic [DATA_W-1:0] meanVal;
  logic [D_W-1:0]    e0, e1, e2, e3;
  logic signed [D_W-1:0] deriv;
  logic signed [P_W-1:0] tProd;
  logic [P_W-1:0]    tMag, qMag;
  logic [P_W+RS:0]   qProd;
  logic signed [T_W-1:0] corr, total;
  logic [DATA_W-1:0] predNext;
  logic [1:0]        predLvl, actualLvl;

  function automatic logic [1:0] levelOf(input logic [DATA_W-1:0] v, input logic four,
                                         input logic [DATA_W-1:0] t0, input logic [DATA_W-1:0] t1,
                                         input logic [DATA_W-1:0] t2);
    if (!four)   return {1'b0, v > t0};
    if (v > t2)  return 2'd3;
    if (v > t1)  return 2'd2;
    if (v > t0)  return 2'd1;
    return 2'd0;
  endfunction

  // Window as it stands after the new sample is shifted in
  always_comb begin
    win[0] = sampleVal;
    for (int i = 1; i < HIST; i++) win[i] = hist[sampleIdx][i-1];
  end

  always_comb begin
    seenNew = (seenCnt[sampleIdx] >= 3'(HIST)) ? 3'(HIST) : seenCnt[sampleIdx] + 3'd1;
    if (winLen == 3'd0)           effK = 3'd1;
    else if (winLen > 3'(HIST))   effK = 3'(HIST);
    else                          effK = winLen;
    nUse = (effK < seenNew) ? effK : seenNew;
    winSum = '0;
    for (int i = 0; i < HIST; i++)
      if (3'(i) < nUse) winSum = winSum + SUM_W'(win[i]);
    case (nUse)
      3'd2:    recipSel = RCP2;
      3'd3:    recipSel = RCP3;
      3'd4:    recipSel = RCP4;
      3'd5:    recipSel = RCP5;
      default: recipSel = RCP1;
    endcase
  end

  assign meanProd = winSum * recipSel;
  assign meanVal  = meanProd[RS +: DATA_W];

  // Trend: mean difference of the newest point against the three before it
  always_comb begin
    e0 = D_W'(win[0]);
    e1 = D_W'(win[1]);
    e2 = D_W'(win[2]);
    e3 = D_W'(win[3]);
    deriv = signed'((e0 + e0 + e0) - e1 - e2 - e3);
    tProd = P_W'(deriv) * signed'(P_W'(trendWeight));
    tMag  = (tProd < 0) ? P_W'(-tProd) : P_W'(tProd);
    qProd = tMag * recipSelTrend();
    qMag  = P_W'(qProd >> (RS + WGT_FRAC));
    if (seenNew < 3'd4)   corr = '0;
    else if (tProd < 0)   corr = -signed'(T_W'(qMag));
    else                  corr = signed'(T_W'(qMag));
    total = signed'(T_W'(meanVal)) + corr;
    if (total < 0)          predNext = '0;
    else if (total > TOP_V) predNext = '1;
    else                    predNext = total[DATA_W-1:0];
  end

  function automatic logic [RS:0] recipSelTrend();
    return RCP3;
  endfunction

  assign predLvl      = levelOf(predNext, fourLevel, thrLo, thrMid, thrHi);
  assign actualLvl    = levelOf(sampleVal, fourLevel, thrLo, thrMid, thrHi);
  assign levelDiffers = actualLvl != storedLvl[sampleIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSS; s++) begin
        seenCnt[s]   <= '0;
        storedLvl[s] <= '0;
        for (int i = 0; i < HIST; i++) hist[s][i] <= '0;
      end
      outValid <= 1'b0;
      outIdx   <= '0;
      outVal   <= '0;
      outLevel <= '0;
    end else begin
      outValid <= strb.push;
      if (strb.push) begin
        for (int i = 0; i < HIST; i++) hist[sampleIdx][i] <= win[i];
        seenCnt[sampleIdx]   <= seenNew;
        storedLvl[sampleIdx] <= predLvl;
        outIdx   <= sampleIdx;
        outVal   <= predNext;
        outLevel <= predLvl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      missCount <= '0;
      cmpCount  <= '0;
    end else begin
      if (strb.compare) cmpCount  <= cmpCount + 1'b1;
      if (strb.miss)    missCount <= missCount + 1'b1;
    end
  end

  // R3
  out_follows_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> outValid);
  // R3
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.push |=> !outValid);
  // R8
  miss_le_cmp_chk: assert property (@(posedge clk) disable iff (!rstN)
    missCount <= cmpCount);
  // R8
  cmp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.compare && !strb.clear |=> cmpCount == $past(cmpCount) + 1'b1);
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cmpCount == '0 && missCount == '0));
  // R6
  two_level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && !fourLevel |=> outLevel <= 2'd1);

endmodule

// File: rtl/usage_pred_top.sv
module usage_pred_top
  import usage_pred_pkg::*;
#(
  parameter int NSS      = 32,
  parameter int DATA_W   = 8,
  parameter int WGT_W    = 3,
  parameter int WGT_FRAC = 3,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(NSS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [IDX_W-1:0]  sampleIdx,
  input  logic [DATA_W-1:0] sampleVal,
  input  logic [2:0]        winLen,
  input  logic [WGT_W-1:0]  trendWeight,
  input  logic              fourLevel,
  input  logic [DATA_W-1:0] thrLo,
  input  logic [DATA_W-1:0] thrMid,
  input  logic [DATA_W-1:0] thrHi,
  input  logic              cntClear,
  output logic              predValid,
  output logic [IDX_W-1:0]  predIdx,
  output logic [DATA_W-1:0] predVal,
  output logic [1:0]        predLevel,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  cmpCount
);

  dpStrobes_t strb;
  logic       levelDiffers;

  usage_pred_ctrl #(.NSS(NSS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIdx(sampleIdx),
    .cntClear(cntClear), .levelDiffers(levelDiffers), .strb(strb)
  );

  usage_pred_dp #(.NSS(NSS), .DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC),
                  .CNT_W(CNT_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIdx(sampleIdx), .sampleVal(sampleVal),
    .winLen(winLen), .trendWeight(trendWeight), .fourLevel(fourLevel),
    .thrLo(thrLo), .thrMid(thrMid), .thrHi(thrHi), .levelDiffers(levelDiffers),
    .outValid(predValid), .outIdx(predIdx), .outVal(predVal), .outLevel(predLevel),
    .missCount(missCount), .cmpCount(cmpCount)
  );

endmodule

// File: tb/usage_pred_tb.sv
`timescale 1ns/1ps
module usage_pred_top_tb_top;

  localparam int NSS = 4;
  localparam int DATA_W = 8;
  localparam int WGT_W = 3;
  localparam int WGT_FRAC = 3;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [1:0] sampleIdx = '0;
  logic [DATA_W-1:0] sampleVal = '0;
  logic [2:0] winLen = 3'd1;
  logic [WGT_W-1:0] trendWeight = '0;
  logic fourLevel = 1'b0;
  logic [DATA_W-1:0] thrLo = 8'd100, thrMid = 8'd150, thrHi = 8'd200;
  logic cntClear = 1'b0;
  logic predValid;
  logic [1:0] predIdx;
  logic [DATA_W-1:0] predVal;
  logic [1:0] predLevel;
  logic [CNT_W-1:0] missCount, cmpCount;

  always #2.5 clk = ~clk;

  usage_pred_top #(.NSS(NSS), .DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC),
                   .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIdx(sampleIdx),
    .sampleVal(sampleVal), .winLen(winLen), .trendWeight(trendWeight),
    .fourLevel(fourLevel), .thrLo(thrLo), .thrMid(thrMid), .thrHi(thrHi),
    .cntClear(cntClear), .predValid(predValid), .predIdx(predIdx), .predVal(predVal),
    .predLevel(predLevel), .missCount(missCount), .cmpCount(cmpCount)
  );

  int nChecks = 0, nErrors = 0;
  bit started = 0, done = 0;

  // Reference model state
  int mHist [NSS][5];
  int mSeen [NSS];
  bit mHave [NSS];
  int mLvl [NSS];
  int expMiss = 0, expCmp = 0;

  int qIdx[$], qVal[$], qLvl[$];
  string qTag[$], qLvlTag[$];

  function automatic void chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic int lvlOf(int v);
    if (!fourLevel) return (v > thrLo) ? 1 : 0;
    if (v > thrHi) return 3;
    if (v > thrMid) return 2;
    if (v > thrLo) return 1;
    return 0;
  endfunction

  // Driver: enter and leave at a falling edge
  task automatic sendSample(int idx, int val, string tag, bit withClr = 0);
    int k, n, sum, mean, corr, p;
    if (mHave[idx]) begin
      expCmp++;
      if (lvlOf(val) != mLvl[idx]) expMiss++;
    end
    if (withClr) begin expCmp = 0; expMiss = 0; end
    for (int i = 4; i > 0; i--) mHist[idx][i] = mHist[idx][i-1];
    mHist[idx][0] = val;
    if (mSeen[idx] < 5) mSeen[idx]++;
    k = (winLen == 0) ? 1 : ((winLen > 5) ? 5 : int'(winLen));
    n = (k < mSeen[idx]) ? k : mSeen[idx];
    sum = 0;
    for (int i = 0; i < n; i++) sum += mHist[idx][i];
    mean = sum / n;
    corr = 0;
    if (mSeen[idx] >= 4)
      corr = (int'(trendWeight) * (3*mHist[idx][0] - mHist[idx][1] - mHist[idx][2] - mHist[idx][3]))
             / (3 * (1 << WGT_FRAC));
    p = mean + corr;
    if (p < 0) p = 0;
    if (p > 255) p = 255;
    mLvl[idx] = lvlOf(p);
    mHave[idx] = 1;
    qIdx.push_back(idx); qVal.push_back(p); qLvl.push_back(mLvl[idx]);
    qTag.push_back(tag); qLvlTag.push_back(fourLevel ? "R7" : "R6");
    sampleValid = 1'b1; sampleIdx = 2'(idx); sampleVal = 8'(val); cntClear = withClr;
    @(negedge clk);
    sampleValid = 1'b0; cntClear = 1'b0;
  endtask

  task automatic clearCounters();
    expCmp = 0; expMiss = 0;
    cntClear = 1'b1;
    @(negedge clk);
    cntClear = 1'b0;
  endtask

  task automatic checkCounters(string tag);
    chk(cmpCount == CNT_W'(expCmp), tag, int'(cmpCount), expCmp);
    chk(missCount == CNT_W'(expMiss), tag, int'(missCount), expMiss);
  endtask

  // Monitor: score each forecast as it appears
  always @(negedge clk) begin
    if (started && predValid) begin
      if (qIdx.size() == 0) begin
        chk(0, "R3 unexpected predValid", 1, 0);
      end else begin
        int ei, ev, el;
        string t, lt;
        ei = qIdx.pop_front(); ev = qVal.pop_front(); el = qLvl.pop_front();
        t = qTag.pop_front(); lt = qLvlTag.pop_front();
        chk(int'(predIdx) == ei, "R3 predIdx", int'(predIdx), ei);
        chk(int'(predVal) == ev, t, int'(predVal), ev);
        chk(int'(predLevel) == el, lt, int'(predLevel), el);
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    for (int s = 0; s < NSS; s++) begin
      mSeen[s] = 0; mHave[s] = 0; mLvl[s] = 0;
      for (int i = 0; i < 5; i++) mHist[s][i] = 0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(predValid == 1'b0, "R10 predValid", int'(predValid), 0);
    chk(cmpCount == '0, "R10 cmpCount", int'(cmpCount), 0);
    chk(missCount == '0, "R10 missCount", int'(missCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    started = 1;
    chk(predValid == 1'b0, "R3 idle", int'(predValid), 0);

    // R1 k=1 previous-sample forecast, R6 two-level quantizing
    winLen = 3'd1; trendWeight = '0; fourLevel = 1'b0;
    sendSample(0, 50, "R1 k1");
    sendSample(0, 120, "R1 k1");
    sendSample(0, 100, "R6 boundary");
    sendSample(0, 101, "R6 above");
    checkCounters("R8 after two-level run");

    // R1 warm-up averaging with k=3, R2 interleaved regions
    winLen = 3'd3;
    sendSample(1, 10, "R1 warm1");
    sendSample(2, 200, "R2 other region");
    sendSample(1, 20, "R1 warm2");
    sendSample(2, 100, "R2 other region");
    sendSample(1, 30, "R1 full3");
    sendSample(1, 40, "R1 slide3");
    winLen = 3'd5; sendSample(1, 50, "R1 k5");
    sendSample(1, 61, "R1 k5 floor");
    winLen = 3'd4; sendSample(1, 70, "R1 k4");
    winLen = 3'd2; sendSample(2, 33, "R2 k2 own history");
    winLen = 3'd0; sendSample(3, 9, "R1 k0 as 1");
    sendSample(3, 13, "R1 k0 as 1");
    winLen = 3'd7; sendSample(1, 80, "R1 k7 as 5");
    checkCounters("R8 mixed");

    // R4 trend term and R5 clamps
    winLen = 3'd1; trendWeight = 3'd4;
    sendSample(3, 20, "R4 under four samples");
    sendSample(3, 30, "R4 rising");
    sendSample(3, 40, "R4 rising");
    trendWeight = 3'd7;
    sendSample(0, 0, "R5 clamp low");
    sendSample(3, 255, "R5 clamp high");
    trendWeight = 3'd0;
    sendSample(3, 200, "R4 weight zero");
    trendWeight = 3'd5; winLen = 3'd3;
    sendSample(2, 20, "R4 falling mean3");

    // R7 four-level boundaries
    fourLevel = 1'b1; trendWeight = '0; winLen = 3'd1;
    thrLo = 8'd50; thrMid = 8'd100; thrHi = 8'd150;
    sendSample(1, 50, "R7 at lo");
    sendSample(1, 51, "R7 above lo");
    sendSample(1, 100, "R7 at mid");
    sendSample(1, 101, "R7 above mid");
    sendSample(1, 150, "R7 at hi");
    sendSample(1, 151, "R7 above hi");
    sendSample(1, 10, "R8 miss expected");
    checkCounters("R8 four-level");

    // R9 clear, clear with a simultaneous comparison, histories kept
    clearCounters();
    checkCounters("R9 cleared");
    sendSample(1, 200, "R9 history kept");
    checkCounters("R8 after clear");
    sendSample(1, 20, "R9 clear wins", 1'b1);
    checkCounters("R9 clear wins");
    winLen = 3'd3;
    sendSample(1, 30, "R9 history kept window");
    checkCounters("R8 final");

    repeat (3) @(negedge clk);
    chk(qIdx.size() == 0, "R3 missing forecasts", qIdx.size(), 0);
    done = 1;
    finishRun();
  end

endmodule